// File: doc/BRIEF.md
# Interrupt Status and Enable Aggregator

This block collects single-cycle event pulses from a parameterised number of hardware sources and combines them into one interrupt line. Each source has a sticky pending flag and an enable bit. The line is raised while any source is both pending and enabled.

Software reaches the block through a small request port with valid, write, address, data and byte strobes. Each read returns data one cycle after the request. Pending flags are acknowledged by writing ones, so no read-modify-write sequence is needed. The enable mask can be replaced as a whole word. It can also be changed one bit at a time through a set-only alias and a clear-only alias. A software update therefore never loses a flag that hardware raises in the same cycle. A read-only view returns pending AND enable, which lets a handler find its sources in a single read.

Register map (byte offsets, word aligned; any other offset, or a request whose two low address bits are not zero, is unmapped):
- 0x00 pending flags
- 0x04 enable mask, full word
- 0x08 enable set alias
- 0x0C enable clear alias
- 0x10 enabled-and-pending view

Top module: `irq_aggr`

## Requirements
- R1: An event pulse on bit i of `evt_i` sets pending bit i at the next clock edge. The bit stays set after more pulses until software clears it.
- R2: A write to offset 0x00 clears each pending bit i for which data bit i is 1 and byte strobe i/8 is 1. Every other pending bit is left as it was.
- R3: If an event on bit i arrives in the same cycle as a software clear of pending bit i, the bit is left set.
- R4: A write to offset 0x04 loads enable bit i from data bit i only where byte strobe i/8 is 1. A read of 0x04 returns the current mask.
- R5: A write to offset 0x08 sets each enable bit whose data bit and strobe lane are both 1, and leaves the others unchanged. Reads of 0x08 return zero.
- R6: A write to offset 0x0C clears each enable bit whose data bit and strobe lane are both 1, and leaves the others unchanged. Reads of 0x0C return zero.
- R7: Reads of offset 0x10 return pending AND enable. Writes to 0x10 change nothing.
- R8: `irq_o` is registered. It is high in the cycle after any pending-and-enabled bit exists, and it falls one cycle after the last such bit is cleared or masked.
- R9: A write to any enable alias never changes a pending bit.
- R10: A read request yields `rsp_valid_o` high for exactly the next cycle. Its data is the register value before that cycle's edge. Bits at or above the source count read zero, and unmapped offsets read zero with writes to them ignored.
- R11: After reset all pending and enable bits are zero, and `irq_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSRC | Single-cycle event pulse per source |
| req_valid_i | input | 1 | Register request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address of the request |
| req_wdata_i | input | DW | Write data |
| req_wstrb_i | input | DW/8 | Byte strobes for the write |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata_o | output | DW | Read data |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that the event inputs are pulses sampled at the clock edge and that at most one register request arrives per cycle. They also assume that any input is allowed while reset is asserted, because every property is disabled until reset is released. The stimulus drives every input on the falling edge and holds each request for exactly one cycle. It issues one request at a time, which keeps the read-latency and alias-data properties within their stated premise. Same-cycle event and clear collisions are produced on purpose, so the property that lets the event win is exercised rather than only assumed.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
   // word indices of the register map (byte offset / 4)
   localparam int unsigned IDX_PEND   = 0;
   localparam int unsigned IDX_EN     = 1;
   localparam int unsigned IDX_EN_SET = 2;
   localparam int unsigned IDX_EN_CLR = 3;
   localparam int unsigned IDX_VIEW   = 4;
   localparam int unsigned NUM_WORDS  = 5;

   typedef struct packed {
      logic pend_wr;
      logic en_wr;
      logic en_set;
      logic en_clr;
   } wr_sel_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend_o[i] <= 1'b0;
         else if (evt_i[i]) pend_o[i] <= 1'b1;
         else if (clr_i[i]) pend_o[i] <= 1'b0;
      end

      a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[i] |=> pend_o[i]);
      a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
      a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && !evt_i[i]) |=> !pend_o[i]);
      a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[i] && evt_i[i]) |=> pend_o[i]);
      a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         (!pend_o[i] && !evt_i[i]) |=> !pend_o[i]);
   end
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_full_i,
   input  logic         wr_set_i,
   input  logic         wr_clr_i,
   input  logic [N-1:0] data_i,   // write data already gated by strobe lanes
   input  logic [N-1:0] lanes_i,  // bits covered by an active strobe
   output logic [N-1:0] en_o
);
   logic [N-1:0] en_d;

   always_comb begin
      en_d = en_o;
      if (wr_full_i)     en_d = (en_o & ~lanes_i) | data_i;
      else if (wr_set_i) en_d = en_o | data_i;
      else if (wr_clr_i) en_d = en_o & ~data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_o <= '0;
      else        en_o <= en_d;
   end

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_full_i || wr_set_i || wr_clr_i) |=> $stable(en_o));
   a_r4_lanes_kept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_full_i |=> ((en_o ^ $past(en_o)) & ~$past(lanes_i)) == '0);
   a_r5_set_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set_i |=> ((en_o & $past(data_i)) == $past(data_i))
                && ((en_o & ~$past(data_i)) == ($past(en_o) & ~$past(data_i))));
   a_r6_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr_i |=> ((en_o & $past(data_i)) == '0)
                && ((en_o & ~$past(data_i)) == ($past(en_o) & ~$past(data_i))));
endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
   import irq_aggr_pkg::*;
#(
   parameter int unsigned N  = 8,
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid_i,
   input  logic            req_write_i,
   input  logic [AW-1:0]   req_addr_i,
   input  logic [DW-1:0]   req_wdata_i,
   input  logic [DW/8-1:0] req_wstrb_i,
   input  logic [N-1:0]    pend_i,
   input  logic [N-1:0]    en_i,
   output wr_sel_t         sel_o,
   output logic [N-1:0]    data_o,
   output logic [N-1:0]    lanes_o,
   output logic            rsp_valid_o,
   output logic [DW-1:0]   rsp_rdata_o
);
   localparam int unsigned SW = DW / 8;
   localparam int unsigned IW = AW - 2;

   logic [DW-1:0] lane_full;
   logic [IW-1:0] idx;
   logic          aligned;
   logic          rd_req;
   logic          wr_req;
   logic [DW-1:0] rd_word;
   logic          unused_hi;

   for (genvar b = 0; b < SW; b++) begin : g_lane
      assign lane_full[b*8 +: 8] = {8{req_wstrb_i[b]}};
   end

   assign idx     = req_addr_i[AW-1:2];
   assign aligned = (req_addr_i[1:0] == 2'b00);
   assign rd_req  = req_valid_i && !req_write_i;
   assign wr_req  = req_valid_i && req_write_i && aligned;

   assign lanes_o   = lane_full[N-1:0];
   assign data_o    = req_wdata_i[N-1:0] & lane_full[N-1:0];
   assign unused_hi = ^{req_wdata_i, lane_full};

   always_comb begin
      sel_o         = '0;
      sel_o.pend_wr = wr_req && (idx == IW'(IDX_PEND));
      sel_o.en_wr   = wr_req && (idx == IW'(IDX_EN));
      sel_o.en_set  = wr_req && (idx == IW'(IDX_EN_SET));
      sel_o.en_clr  = wr_req && (idx == IW'(IDX_EN_CLR));
   end

   always_comb begin
      rd_word = '0;
      if (aligned) begin
         if (idx == IW'(IDX_PEND))      rd_word[N-1:0] = pend_i;
         else if (idx == IW'(IDX_EN))   rd_word[N-1:0] = en_i;
         else if (idx == IW'(IDX_VIEW)) rd_word[N-1:0] = pend_i & en_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= rd_req;
         if (rd_req) rsp_rdata_o <= rd_word;
      end
   end

   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rsp_valid_o);
   a_r10_rsp_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rsp_valid_o);
   a_r5_set_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && idx == IW'(IDX_EN_SET)) |=> rsp_rdata_o == '0);
   a_r6_clr_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && idx == IW'(IDX_EN_CLR)) |=> rsp_rdata_o == '0);
   a_r7_view_is_and: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && aligned && idx == IW'(IDX_VIEW))
         |=> rsp_rdata_o[N-1:0] == ($past(pend_i) & $past(en_i)));
   a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));
endmodule

// File: rtl/irq_aggr.sv
module irq_aggr
   import irq_aggr_pkg::*;
#(
   parameter int unsigned NSRC = 12,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_i,
   input  logic            req_valid_i,
   input  logic            req_write_i,
   input  logic [AW-1:0]   req_addr_i,
   input  logic [DW-1:0]   req_wdata_i,
   input  logic [DW/8-1:0] req_wstrb_i,
   output logic            rsp_valid_o,
   output logic [DW-1:0]   rsp_rdata_o,
   output logic            irq_o
);
   if (NSRC < 1 || NSRC > DW) begin : g_bad_nsrc
      $error("irq_aggr: NSRC must lie in 1..DW");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("irq_aggr: DW must be a positive multiple of 8");
   end
   if ((1 << (AW - 2)) < NUM_WORDS) begin : g_bad_aw
      $error("irq_aggr: AW too small for the register map");
   end

   wr_sel_t         sel;
   logic [NSRC-1:0] wdata;
   logic [NSRC-1:0] lanes;
   logic [NSRC-1:0] pend;
   logic [NSRC-1:0] en;
   logic [NSRC-1:0] clr;
   logic            any_live;

   irq_csr_port #(.N(NSRC), .DW(DW), .AW(AW)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_addr_i  (req_addr_i),
      .req_wdata_i (req_wdata_i),
      .req_wstrb_i (req_wstrb_i),
      .pend_i      (pend),
      .en_i        (en),
      .sel_o       (sel),
      .data_o      (wdata),
      .lanes_o     (lanes),
      .rsp_valid_o (rsp_valid_o),
      .rsp_rdata_o (rsp_rdata_o)
   );

   assign clr = sel.pend_wr ? wdata : '0;

   irq_pend_bank #(.N(NSRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .clr_i  (clr),
      .pend_o (pend)
   );

   irq_en_bank #(.N(NSRC)) u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_full_i (sel.en_wr),
      .wr_set_i  (sel.en_set),
      .wr_clr_i  (sel.en_clr),
      .data_i    (wdata),
      .lanes_i   (lanes),
      .en_o      (en)
   );

   assign any_live = |(pend & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= any_live;
   end

   a_r8_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
      any_live |=> irq_o);
   a_r8_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
      !any_live |=> !irq_o);
   a_r9_enable_spares_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (sel.en_wr || sel.en_set || sel.en_clr)
         |=> pend == ($past(pend) | $past(evt_i)));
   a_r7_view_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_write_i && !(sel.pend_wr || sel.en_wr || sel.en_set || sel.en_clr))
         |=> (pend == ($past(pend) | $past(evt_i))) && (en == $past(en)));
endmodule

// File: tb/irq_aggr_test.sv
`timescale 1ns/1ps
module irq_aggr_test;
   localparam int NSRC = 12;
   localparam int DW   = 32;
   localparam int AW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] evt_i = '0;
   logic            req_valid_i = 1'b0;
   logic            req_write_i = 1'b0;
   logic [AW-1:0]   req_addr_i = '0;
   logic [DW-1:0]   req_wdata_i = '0;
   logic [DW/8-1:0] req_wstrb_i = '0;
   logic            rsp_valid_o;
   logic [DW-1:0]   rsp_rdata_o;
   logic            irq_o;

   int checks = 0;
   int fails  = 0;
   logic [NSRC-1:0] m_pend = '0;
   logic [NSRC-1:0] m_en   = '0;
   logic [DW-1:0]   exp_q[$];
   string           tag_q[$];

   always #4 clk = ~clk;

   irq_aggr #(.NSRC(NSRC), .DW(DW), .AW(AW)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .req_valid_i(req_valid_i), .req_write_i(req_write_i),
      .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
      .req_wstrb_i(req_wstrb_i), .rsp_valid_o(rsp_valid_o),
      .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [NSRC-1:0] lanes(input logic [DW/8-1:0] s);
      logic [DW-1:0] f;
      for (int b = 0; b < DW/8; b++) f[b*8 +: 8] = {8{s[b]}};
      return f[NSRC-1:0];
   endfunction

   // monitor: pops expected read data as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid_o) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected response", 32'h1, 32'h0);
         end else begin
            check(tag_q.pop_front(), rsp_rdata_o, exp_q.pop_front());
         end
      end
   end

   // driver: one request, then idle; model updated after the edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [DW/8-1:0] s, input logic [NSRC-1:0] ev);
      logic [NSRC-1:0] g;
      g = d[NSRC-1:0] & lanes(s);
      req_valid_i = 1'b1; req_write_i = 1'b1;
      req_addr_i = a; req_wdata_i = d; req_wstrb_i = s; evt_i = ev;
      @(negedge clk);
      req_valid_i = 1'b0; req_write_i = 1'b0; req_wstrb_i = '0; evt_i = '0;
      case (a)
         5'h00: m_pend = m_pend & ~g;
         5'h04: m_en = (m_en & ~lanes(s)) | g;
         5'h08: m_en = m_en | g;
         5'h0C: m_en = m_en & ~g;
         default: ;
      endcase
      m_pend = m_pend | ev;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      logic [DW-1:0] e;
      e = '0;
      case (a)
         5'h00: e[NSRC-1:0] = m_pend;
         5'h04: e[NSRC-1:0] = m_en;
         5'h10: e[NSRC-1:0] = m_pend & m_en;
         default: ;
      endcase
      exp_q.push_back(e);
      tag_q.push_back(tag);
      req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
      @(negedge clk);
      req_valid_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse(input logic [NSRC-1:0] ev);
      evt_i = ev;
      @(negedge clk);
      evt_i = '0;
      m_pend = m_pend | ev;
   endtask

   task automatic irq_settled(input string tag);
      @(negedge clk);
      check(tag, {31'd0, irq_o}, {31'd0, |(m_pend & m_en)});
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      check("watchdog expired", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R11 irq after reset", {31'd0, irq_o}, 32'd0);
      check("R11 rsp_valid after reset", {31'd0, rsp_valid_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(5'h00, "R11 pending reset");
      rd(5'h04, "R11 enable reset");

      pulse(12'h005);
      rd(5'h00, "R1 event sets");
      irq_settled("R8 masked source no irq");
      pulse(12'h001);
      rd(5'h00, "R1 sticky on repeat");

      wr(5'h04, 32'h0000_0F0F, 4'hF, '0);
      rd(5'h04, "R4 full enable readback");
      rd(5'h10, "R7 view is and");
      irq_settled("R8 irq raised");
      wr(5'h04, 32'h0, 4'h2, '0);
      rd(5'h04, "R4 strobe lane only");

      wr(5'h08, 32'h0000_0300, 4'hF, '0);
      rd(5'h04, "R5 set alias");
      rd(5'h08, "R5 set alias reads zero");
      wr(5'h0C, 32'h0000_000C, 4'hF, '0);
      rd(5'h04, "R6 clear alias");
      rd(5'h0C, "R6 clear alias reads zero");
      rd(5'h00, "R9 pending untouched by enable");

      wr(5'h10, 32'hFFFF_FFFF, 4'hF, '0);
      rd(5'h10, "R7 view write inert");
      rd(5'h00, "R7 pending after view write");

      wr(5'h00, 32'h0000_0004, 4'hF, '0);
      rd(5'h00, "R2 write one clears");
      wr(5'h00, 32'h0000_0FFF, 4'h2, '0);
      rd(5'h00, "R2 strobe off keeps bit");
      wr(5'h00, 32'h0000_0001, 4'hF, 12'h001);
      rd(5'h00, "R3 event beats clear");
      irq_settled("R8 irq still high");

      // clear the last live bit: irq falls one cycle later
      wr(5'h00, 32'h0000_0001, 4'hF, '0);
      check("R8 irq registered delay", {31'd0, irq_o}, 32'd1);
      irq_settled("R8 irq falls");

      pulse(12'h100);
      irq_settled("R8 irq from bit 8");
      wr(5'h0C, 32'h0000_0100, 4'hF, '0);
      irq_settled("R8 irq masked off");
      rd(5'h00, "R9 pending kept when masked");

      wr(5'h14, 32'hFFFF_FFFF, 4'hF, '0);
      rd(5'h14, "R10 unmapped reads zero");
      rd(5'h04, "R10 unmapped write ignored");
      wr(5'h05, 32'h0000_0FFF, 4'hF, '0);
      rd(5'h04, "R10 unaligned write ignored");

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) check("R10 missing responses", exp_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule